// File: doc/BRIEF.md
# GPIO Interrupt Detection Bank

This block watches a bank of general-purpose input pins and turns activity on them into one combined interrupt request. Each pin first passes through a two-stage synchroniser. A per-pin detector then compares the synchronised value with its value one cycle earlier to find edges, and evaluates the current value to find levels. Three per-pin configuration bits choose the event: level or edge, which polarity, and whether both edges count. The selected event sets a sticky status bit, and a mask bit decides whether that status bit reaches the shared interrupt output.

Masking never stops detection. It only holds back propagation, so an event that arrives while a pin is masked is still recorded and raises the interrupt as soon as the pin is unmasked. Software acknowledges by writing ones to the status register. The acknowledge takes effect only when the pin's detect condition is false in that cycle. A level source that is still active therefore keeps its bit set. An edge, which is true for one cycle only, can be acknowledged at any later time.

Access is through a simple single-cycle write strobe with a combinational read-back of the addressed register.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the type, polarity, any-edge, status and level registers read 0, the mask register reads all ones, and `irq` is 0.
- R2: A type bit of 0 selects level detection for that pin and 1 selects edge detection. Only the selected detector can set the pin's status bit, and a status bit never rises without a detected event.
- R3: In edge mode with any-edge 0, polarity 0 triggers on a rising edge and polarity 1 triggers on a falling edge. With any-edge 1, both edges trigger and polarity has no effect.
- R4: In level mode, polarity 0 makes a high level the condition and polarity 1 makes a low level the condition. The any-edge bit has no effect in level mode.
- R5: Writing 1 to a bit of the status register clears it when that pin's condition is false in the write cycle. If the condition is true, the bit stays 1. Writing 0 bits, or cycles with no status write, never clear a status bit.
- R6: When a detected event and a clearing write hit the same status bit in the same cycle, the bit ends up 1.
- R7: `irq` is 1 exactly when some pin has status 1 and mask 0. A mask bit of 1 disables that pin.
- R8: Detection and status setting continue on masked pins. Clearing the mask bit of a pin with pending status raises `irq` in the cycle after the mask write.
- R9: The level register (address 5) returns the synchronised pin values, which follow a pin change after two clock edges. Writes to it have no effect.
- R10: Register map by `addr`: 0 type, 1 polarity, 2 any-edge, 3 mask, 4 status (write-one-to-clear), 5 level (read-only). Addresses 6 and 7 read 0. Registers 0 to 3 read back what was last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| pin_in | input | NPINS | Raw, asynchronous pin levels |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Combinational read data for `addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench assigns all eight combinations of type, polarity and any-edge across the pins, eight pins per full set of combinations. It then steps the pins through a sequence of whole-bank patterns: all-zero to all-one and back, alternating bits, half-words, nibbles and scrambled words. Each transition therefore presents every configuration with rising edges, falling edges and steady levels at once, and a status bit that is set in the wrong mode or on the wrong polarity shows up as a mismatch on a specific pin. Between steps it acknowledges every bit and checks that exactly the pins whose level condition still holds stay set, which separates level behaviour from edge behaviour. Separate sequences place an edge in the same cycle as an acknowledge, raise an edge on a masked pin, and measure the synchroniser latency.

// File: rtl/gib_pkg.sv
package gib_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_TYPE   = 3'd0;
  localparam logic [ADDR_W-1:0] A_POL    = 3'd1;
  localparam logic [ADDR_W-1:0] A_ANY    = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] A_LEVEL  = 3'd5;
endpackage

// File: rtl/gib_sync.sv
module gib_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gib_detect.sv
module gib_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] cfg_edge,
  input  logic [W-1:0] cfg_inv,
  input  logic [W-1:0] cfg_both,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, edge_ev, level_ev;
    always_comb begin
      rise     = lvl[i] & ~prev_q[i];
      fall     = ~lvl[i] & prev_q[i];
      edge_ev  = cfg_both[i] ? (rise | fall) : (cfg_inv[i] ? fall : rise);
      level_ev = cfg_inv[i] ? ~lvl[i] : lvl[i];
      hit[i]   = cfg_edge[i] ? edge_ev : level_ev;
    end
  end
endmodule

// File: rtl/gib_regs.sv
module gib_regs
  import gib_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      hit,
  input  logic [W-1:0]      lvl,
  output logic [W-1:0]      cfg_edge,
  output logic [W-1:0]      cfg_inv,
  output logic [W-1:0]      cfg_both,
  output logic [W-1:0]      mask,
  output logic [W-1:0]      status,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] edge_q, inv_q, both_q, mask_q, status_q;
  logic [W-1:0] status_d, clr;
  logic         we_edge, we_inv, we_both, we_mask;

  always_comb begin
    we_edge  = wr_en && (addr == A_TYPE);
    we_inv   = wr_en && (addr == A_POL);
    we_both  = wr_en && (addr == A_ANY);
    we_mask  = wr_en && (addr == A_MASK);
    clr      = (wr_en && (addr == A_STATUS)) ? wdata : '0;
    status_d = hit | (status_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q   <= '0;
      inv_q    <= '0;
      both_q   <= '0;
      mask_q   <= '1;
      status_q <= '0;
    end else begin
      if (we_edge) edge_q <= wdata;
      if (we_inv)  inv_q  <= wdata;
      if (we_both) both_q <= wdata;
      if (we_mask) mask_q <= wdata;
      status_q <= status_d;
    end
  end

  always_comb begin
    case (addr)
      A_TYPE:   rdata = edge_q;
      A_POL:    rdata = inv_q;
      A_ANY:    rdata = both_q;
      A_MASK:   rdata = mask_q;
      A_STATUS: rdata = status_q;
      A_LEVEL:  rdata = lvl;
      default:  rdata = '0;
    endcase
  end

  assign cfg_edge = edge_q;
  assign cfg_inv  = inv_q;
  assign cfg_both = both_q;
  assign mask     = mask_q;
  assign status   = status_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gib_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  output logic              irq
);
  logic [NPINS-1:0] lvl, hit, cfg_edge, cfg_inv, cfg_both, mask_q, status_q;

  gib_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(lvl)
  );

  gib_detect #(.W(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(lvl),
    .cfg_edge(cfg_edge), .cfg_inv(cfg_inv), .cfg_both(cfg_both),
    .hit(hit)
  );

  gib_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hit(hit), .lvl(lvl),
    .cfg_edge(cfg_edge), .cfg_inv(cfg_inv), .cfg_both(cfg_both),
    .mask(mask_q), .status(status_q), .rdata(rdata)
  );

  assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/gib_checker.sv
module gib_checker
  import gib_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NPINS-1:0]  hit,
  input logic [NPINS-1:0]  status,
  input logic [NPINS-1:0]  mask,
  input logic              irq
);
  // R6: an event always leaves its status bit set, clearing write or not
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(hit)) == $past(hit)));

  // R2: no status bit rises without a detected event
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(hit)) == '0));

  // R5: without a status write, no bit is cleared
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_STATUS) |=> ((status & $past(status)) == $past(status)));

  // R7: all pins masked keeps the request low
  a_r7_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  // R7: a request needs a pending status bit
  a_r7_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
endmodule

bind gpio_irq_bank gib_checker #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .hit(hit), .status(status_q), .mask(mask_q), .irq(irq)
);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int N = 32;
  localparam logic [2:0] A_TYPE = 3'd0, A_POL = 3'd1, A_ANY = 3'd2,
                         A_MASK = 3'd3, A_STATUS = 3'd4, A_LEVEL = 3'd5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq;

  int n_checks = 0;
  int n_fail   = 0;

  logic [N-1:0] c_typ, c_pol, c_any;

  always #4 clk = ~clk;

  gpio_irq_bank #(.NPINS(N)) u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  function automatic logic [N-1:0] lvl_cond(input logic [N-1:0] v);
    return ~c_typ & ((c_pol & ~v) | (~c_pol & v));
  endfunction

  function automatic logic [N-1:0] edge_ev(input logic [N-1:0] o, input logic [N-1:0] n);
    logic [N-1:0] r, f;
    r = ~o & n;
    f = o & ~n;
    return c_typ & ((c_any & (r | f)) | (~c_any & ~c_pol & r) | (~c_any & c_pol & f));
  endfunction

  function automatic logic [N-1:0] pattern(input int k);
    case (k)
      0: return '0;
      1: return '1;
      2: return '0;
      3: return 32'hAAAA_AAAA;
      4: return 32'h5555_5555;
      5: return 32'hFFFF_0000;
      6: return 32'h0F0F_0F0F;
      7: return 32'h0000_0000;
      default: return (32'h9E37_79B9 * k) ^ (k << 11);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual %h expected %h", 1'b1, 1'b0);
    finish_run();
  end

  initial begin
    logic [N-1:0] d, old_v, new_v, exp;
    for (int i = 0; i < N; i++) begin
      c_typ[i] = i[0];
      c_pol[i] = i[1];
      c_any[i] = i[2];
    end

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values
    rd(A_TYPE, d);   chk("R1 type reset", d, '0);
    rd(A_POL, d);    chk("R1 pol reset", d, '0);
    rd(A_ANY, d);    chk("R1 any reset", d, '0);
    rd(A_MASK, d);   chk("R1 mask reset", d, '1);
    rd(A_STATUS, d); chk("R1 status reset", d, '0);
    rd(A_LEVEL, d);  chk("R1 level reset", d, '0);
    chk("R1 irq reset", N'(irq), '0);

    // R10: register map read-back and unused addresses
    wr(A_TYPE, 32'h1234_5678); rd(A_TYPE, d); chk("R10 type rw", d, 32'h1234_5678);
    wr(A_POL,  32'hCAFE_0001); rd(A_POL, d);  chk("R10 pol rw", d, 32'hCAFE_0001);
    wr(A_ANY,  32'h8000_00FF); rd(A_ANY, d);  chk("R10 any rw", d, 32'h8000_00FF);
    wr(A_MASK, 32'h0F0F_F0F0); rd(A_MASK, d); chk("R10 mask rw", d, 32'h0F0F_F0F0);
    rd(3'd6, d); chk("R10 addr6 zero", d, '0);
    rd(3'd7, d); chk("R10 addr7 zero", d, '0);

    // Full configuration sweep: every type/polarity/any-edge combination
    wr(A_MASK, '1);
    wr(A_TYPE, c_typ);
    wr(A_POL, c_pol);
    wr(A_ANY, c_any);
    settle();
    wr(A_STATUS, '1);
    wr(A_MASK, '0);
    old_v = '0;
    for (int k = 1; k < 14; k++) begin
      new_v = pattern(k);
      wr(A_STATUS, '1);
      rd(A_STATUS, d);
      chk("R5 ack keeps active levels", d, lvl_cond(old_v));
      @(negedge clk) pin_in = new_v;
      settle();
      exp = lvl_cond(old_v) | lvl_cond(new_v) | edge_ev(old_v, new_v);
      rd(A_STATUS, d);
      chk("R2 R3 R4 status after step", d, exp);
      chk("R7 irq unmasked", N'(irq), N'(|exp));
      rd(A_LEVEL, d);
      chk("R9 level follows pins", d, new_v);
      old_v = new_v;
    end

    // R7: fully masked bank keeps irq low with status pending
    wr(A_MASK, '1);
    chk("R7 irq all masked", N'(irq), '0);

    // R5: level-high pin 0 cannot be acknowledged while high
    @(negedge clk) pin_in = '0;
    settle();
    wr(A_STATUS, '1);
    @(negedge clk) pin_in = 32'h1;
    settle();
    wr(A_STATUS, 32'h1);
    rd(A_STATUS, d);
    chk("R5 ack blocked while level high", N'(d[0]), N'(1'b1));
    @(negedge clk) pin_in = '0;
    settle();
    rd(A_STATUS, d);
    chk("R5 level bit sticky after source drops", N'(d[0]), N'(1'b1));
    wr(A_STATUS, 32'h1);
    rd(A_STATUS, d);
    chk("R5 ack clears once level gone", N'(d[0]), '0);

    // R9: two-edge synchroniser latency and read-only level register
    @(negedge clk);
    addr = A_LEVEL;
    pin_in = 32'h4;
    @(posedge clk);
    @(negedge clk);
    chk("R9 level after one edge", N'(rdata[2]), '0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 level after two edges", N'(rdata[2]), N'(1'b1));
    wr(A_LEVEL, '0);
    rd(A_LEVEL, d);
    chk("R9 level write ignored", d, 32'h4);

    // R6: rising edge on pin 1 in the same cycle as its acknowledge
    @(negedge clk) pin_in = '0;
    settle();
    wr(A_STATUS, '1);
    @(negedge clk) pin_in = 32'h2;
    @(posedge clk);
    @(posedge clk);
    wr(A_STATUS, 32'h2);
    rd(A_STATUS, d);
    chk("R6 set wins over ack", N'(d[1]), N'(1'b1));
    wr(A_STATUS, 32'h2);
    rd(A_STATUS, d);
    chk("R5 later ack clears edge bit", N'(d[1]), '0);

    // R8: edge on masked pin 1 is recorded and raises irq on unmask
    @(negedge clk) pin_in = '0;
    settle();
    wr(A_STATUS, '1);
    @(negedge clk) pin_in = 32'h2;
    settle();
    rd(A_STATUS, d);
    chk("R8 masked edge recorded", N'(d[1]), N'(1'b1));
    chk("R8 masked edge no irq", N'(irq), '0);
    wr(A_STATUS, 32'h0);
    rd(A_STATUS, d);
    chk("R5 zero write keeps bit", N'(d[1]), N'(1'b1));
    wr(A_MASK, ~32'h2);
    chk("R8 irq on unmask", N'(irq), N'(1'b1));

    finish_run();
  end
endmodule